// File: doc/BRIEF.md
# I2C Master Command Sequencer and Interrupt Front End

This block is the register-side control front end of one I2C master channel. Software writes a control word, an interrupt enable mask, a byte buffer and a command word. The block turns the command bits into byte-level requests to a separate bus engine, which handles the SCL/SDA bit timing. The request types are start-with-address, transmit byte, receive byte and stop. The engine returns a one-cycle completion pulse together with an ACK/NAK indication, the received byte and a bus-busy level.

A single command write can set several command bits at once. These bits are always carried out in the order start, transmit, receive, stop. Each step waits for the engine to finish before the next begins. While a sequence runs, the register port reports not-ready and ignores writes. A 4-bit transfer-state code follows the sequence and can be read in the command/status word. Results are posted as write-one-to-clear interrupt flags, and an interrupt line is raised for every flag that is also enabled. Clearing the receive-done flag while a receive command is still pending starts that receive.

Register selection by `reg_addr`: 0 control, 1 interrupt enable, 2 interrupt status, 3 byte buffer, 4 command/status. Engine opcodes on `eng_op`: 0 start, 1 transmit, 2 receive, 3 stop/end.

Top module: `i2cm_front`

## Requirements
- R1: After reset the control, enable, status, byte-buffer and command registers read 0, the state code is idle (0x0), `reg_rdy` is 1, and `eng_req` and `irq` are 0.
- R2: Control writes keep only the bits of mask 0x0071C3FF. A command write (address 4) is ignored when control bit 0 (master enable) is clear: no engine request is made and command bits [5:0] read 0.
- R3: Command bit 0 (start) issues opcode 0 with `eng_addr` = buffer bits [7:1] and `eng_rnw` = buffer bit 0. During the request the state code is 0xA if the previous state had bit 3 set, and 0x9 otherwise.
- R4: When a start completes, status bit 0 is set on ACK or bit 1 on NAK, and command bits 0 and 1 clear. If `eng_bus_busy` is low at completion, command bits 3, 4 and 5 clear, no further request is made, and the state stays at its start code.
- R5: Command bit 1 (transmit) issues opcode 1 with buffer bits [7:0], under state 0xC. ACK sets status bit 0. NAK sets status bit 1 and is followed by an opcode 3 request to end the transfer. Afterwards the state is 0x8.
- R6: Command bits 3 (receive) or 4 (receive-last) issue opcode 2, under state 0xE, with `eng_nak_last` equal to bit 4. On completion the byte goes to buffer bits [15:8] with bits [7:0] cleared, status bit 2 is set, bits 3 and 4 clear, and the state becomes 0x8.
- R7: No receive request is made while status bit 2 is set, and the receive bits stay pending. Writing 1 to status bit 2 while receive bits are pending starts the receive.
- R8: Command bit 5 (stop) with state bit 3 clear sets status bit 5 and makes no request. With state bit 3 set it issues opcode 3 under state 0xB and sets status bit 4. In both cases the state then becomes 0x0.
- R9: Command bits set in one write execute in the order start, transmit, receive, stop.
- R10: Status bits [14:0] clear where 1 is written, and other bits are unaffected. The enable register keeps bits [14:0]. `irq` is 1 exactly when some status bit has its enable bit set.
- R11: The command/status read returns the state code in bits [22:19], `eng_bus_busy` in bit 16 and the command field in bits [15:0].
- R12: An engine request and its opcode stay steady until `eng_done`. `reg_rdy` is 0 while a sequence runs, and register writes made then are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| reg_rdy | output | 1 | Register port ready; writes accepted only when 1 |
| eng_req | output | 1 | Engine request, held until eng_done |
| eng_op | output | 2 | Engine opcode: 0 start, 1 transmit, 2 receive, 3 stop/end |
| eng_addr | output | 7 | Target address for a start |
| eng_rnw | output | 1 | Direction for a start (1 = read) |
| eng_wdata | output | 8 | Byte to transmit |
| eng_nak_last | output | 1 | NAK the received byte |
| eng_done | input | 1 | One-cycle completion pulse |
| eng_ack | input | 1 | Target acknowledged (start/transmit) |
| eng_rdata | input | 8 | Received byte, valid with eng_done |
| eng_bus_busy | input | 1 | Bus held by this master |
| irq | output | 1 | Interrupt request |

## Verification
The checker assumes that `eng_done` pulses for one cycle, and only while `eng_req` is high. It also assumes that `eng_ack`, `eng_rdata` and `eng_bus_busy` are valid in the pulse cycle, and that software writes only when `reg_rdy` is high, except where a test probes the ignored-write case on purpose. The bench's engine model meets this. It answers each request after a fixed delay, raises done for one cycle, and changes its ACK, busy and data settings only between sequences. The only write made while not ready is the deliberate R12 probe.

// File: rtl/i2cm_pkg.sv
`timescale 1ns/1ps
package i2cm_pkg;
  localparam int DATA_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int CMD_W    = 16;
  localparam int ST_W     = 4;
  localparam int ST_LSB   = 19;
  localparam int BUSY_BIT = 16;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_TX    = 2'd1,
    OP_RX    = 2'd2,
    OP_STOP  = 2'd3
  } eng_op_e;

  // transfer-state codes; bit 3 marks an owned bus
  localparam logic [ST_W-1:0] XS_IDLE   = 4'h0;
  localparam logic [ST_W-1:0] XS_ACTIVE = 4'h8;
  localparam logic [ST_W-1:0] XS_START  = 4'h9;
  localparam logic [ST_W-1:0] XS_RSTART = 4'hA;
  localparam logic [ST_W-1:0] XS_STOP   = 4'hB;
  localparam logic [ST_W-1:0] XS_TXD    = 4'hC;
  localparam logic [ST_W-1:0] XS_RXD    = 4'hE;
  localparam int XS_OWN_BIT = 3;

  // command bits
  localparam int CB_START  = 0;
  localparam int CB_TX     = 1;
  localparam int CB_RX     = 3;
  localparam int CB_RXLAST = 4;
  localparam int CB_STOP   = 5;

  // interrupt status bits
  localparam int IB_ACK    = 0;
  localparam int IB_NAK    = 1;
  localparam int IB_RXDONE = 2;
  localparam int IB_STOP   = 4;
  localparam int IB_ABN    = 5;

  localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h0071_C3FF;

  // register selects
  localparam int RA_CTRL = 0;
  localparam int RA_IEN  = 1;
  localparam int RA_ISTS = 2;
  localparam int RA_BUF  = 3;
  localparam int RA_CMD  = 4;
endpackage

// File: rtl/i2cm_irq.sv
`timescale 1ns/1ps
module i2cm_irq #(
  parameter int INT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_we,
  input  logic             sts_we,
  input  logic [INT_W-1:0] wdata,
  input  logic [INT_W-1:0] int_set,
  output logic [INT_W-1:0] en_q,
  output logic [INT_W-1:0] sts_q,
  output logic             irq
);
  logic [INT_W-1:0] en_d, sts_d, clr_mask;

  always_comb begin
    clr_mask = sts_we ? wdata : '0;
    sts_d    = (sts_q & ~clr_mask) | int_set;
    en_d     = en_we ? wdata : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sts_q <= '0;
    end else begin
      en_q  <= en_d;
      sts_q <= sts_d;
    end
  end

  assign irq = |(sts_q & en_q);
endmodule

// File: rtl/i2cm_seq.sv
`timescale 1ns/1ps
module i2cm_seq
  import i2cm_pkg::*;
#(
  parameter int INT_W = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_we,
  input  logic [CMD_W-1:0]    cmd_wdata,
  input  logic                rearm,
  input  logic                rx_blocked,
  input  logic [BYTE_W-1:0]   buf_lo,
  output logic                eng_req,
  output eng_op_e             eng_op,
  output logic [BYTE_W-2:0]   eng_addr,
  output logic                eng_rnw,
  output logic [BYTE_W-1:0]   eng_wdata,
  output logic                eng_nak_last,
  input  logic                eng_done,
  input  logic                eng_ack,
  input  logic [BYTE_W-1:0]   eng_rdata,
  input  logic                eng_bus_busy,
  output logic [INT_W-1:0]    int_set,
  output logic                rx_load,
  output logic [BYTE_W-1:0]   rx_byte,
  output logic [CMD_W-1:0]    cmd_q,
  output logic [ST_W-1:0]     xfer_state,
  output logic                seq_idle
);
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_PICK, SQ_START, SQ_TX, SQ_TXEND, SQ_RX, SQ_STOP
  } sq_e;

  sq_e             sq_q, sq_d;
  logic [CMD_W-1:0] cmd_d;
  logic [ST_W-1:0]  st_q, st_d;
  logic             rx_pend;

  assign rx_pend = cmd_q[CB_RX] | cmd_q[CB_RXLAST];

  always_comb begin
    sq_d    = sq_q;
    cmd_d   = cmd_q;
    st_d    = st_q;
    int_set = '0;
    rx_load = 1'b0;
    unique case (sq_q)
      SQ_IDLE: begin
        if (cmd_we) begin
          cmd_d = cmd_wdata;
          sq_d  = SQ_PICK;
        end else if (rearm && rx_pend) begin
          sq_d = SQ_PICK;
        end
      end
      SQ_PICK: begin
        if (cmd_q[CB_START]) begin
          st_d = st_q[XS_OWN_BIT] ? XS_RSTART : XS_START;
          sq_d = SQ_START;
        end else if (cmd_q[CB_TX]) begin
          st_d = XS_TXD;
          sq_d = SQ_TX;
        end else if (rx_pend && !rx_blocked) begin
          st_d = XS_RXD;
          sq_d = SQ_RX;
        end else if (cmd_q[CB_STOP]) begin
          if (!st_q[XS_OWN_BIT]) begin
            int_set[IB_ABN] = 1'b1;
            cmd_d[CB_STOP]  = 1'b0;
            st_d            = XS_IDLE;
            sq_d            = SQ_IDLE;
          end else begin
            st_d = XS_STOP;
            sq_d = SQ_STOP;
          end
        end else begin
          sq_d = SQ_IDLE;
        end
      end
      SQ_START: begin
        if (eng_done) begin
          int_set[eng_ack ? IB_ACK : IB_NAK] = 1'b1;
          cmd_d[CB_START] = 1'b0;
          cmd_d[CB_TX]    = 1'b0;
          if (eng_bus_busy) begin
            st_d = XS_ACTIVE;
            sq_d = SQ_PICK;
          end else begin
            cmd_d[CB_RX]     = 1'b0;
            cmd_d[CB_RXLAST] = 1'b0;
            cmd_d[CB_STOP]   = 1'b0;
            sq_d             = SQ_IDLE;
          end
        end
      end
      SQ_TX: begin
        if (eng_done) begin
          int_set[eng_ack ? IB_ACK : IB_NAK] = 1'b1;
          cmd_d[CB_TX] = 1'b0;
          st_d         = XS_ACTIVE;
          sq_d         = eng_ack ? SQ_PICK : SQ_TXEND;
        end
      end
      SQ_TXEND: begin
        if (eng_done) sq_d = SQ_PICK;
      end
      SQ_RX: begin
        if (eng_done) begin
          rx_load              = 1'b1;
          int_set[IB_RXDONE]   = 1'b1;
          cmd_d[CB_RX]         = 1'b0;
          cmd_d[CB_RXLAST]     = 1'b0;
          st_d                 = XS_ACTIVE;
          sq_d                 = SQ_PICK;
        end
      end
      SQ_STOP: begin
        if (eng_done) begin
          int_set[IB_STOP] = 1'b1;
          cmd_d[CB_STOP]   = 1'b0;
          st_d             = XS_IDLE;
          sq_d             = SQ_IDLE;
        end
      end
      default: sq_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_q  <= SQ_IDLE;
      cmd_q <= '0;
      st_q  <= XS_IDLE;
    end else begin
      sq_q  <= sq_d;
      cmd_q <= cmd_d;
      st_q  <= st_d;
    end
  end

  always_comb begin
    eng_req = 1'b1;
    eng_op  = OP_START;
    unique case (sq_q)
      SQ_START: eng_op = OP_START;
      SQ_TX:    eng_op = OP_TX;
      SQ_RX:    eng_op = OP_RX;
      SQ_TXEND,
      SQ_STOP:  eng_op = OP_STOP;
      default:  eng_req = 1'b0;
    endcase
  end

  assign eng_addr     = buf_lo[BYTE_W-1:1];
  assign eng_rnw      = buf_lo[0];
  assign eng_wdata    = buf_lo;
  assign eng_nak_last = cmd_q[CB_RXLAST];
  assign rx_byte      = eng_rdata;
  assign xfer_state   = st_q;
  assign seq_idle     = (sq_q == SQ_IDLE);
endmodule

// File: rtl/i2cm_front.sv
`timescale 1ns/1ps
module i2cm_front
  import i2cm_pkg::*;
#(
  parameter int AW    = 3,
  parameter int INT_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_rdy,
  output logic              eng_req,
  output logic [1:0]        eng_op,
  output logic [6:0]        eng_addr,
  output logic              eng_rnw,
  output logic [7:0]        eng_wdata,
  output logic              eng_nak_last,
  input  logic              eng_done,
  input  logic              eng_ack,
  input  logic [7:0]        eng_rdata,
  input  logic              eng_bus_busy,
  output logic              irq
);
  localparam int BUF_W = 2 * BYTE_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [BUF_W-1:0]  buf_q, buf_d;
  logic [INT_W-1:0]  en_q, sts_q, int_set;
  logic [CMD_W-1:0]  cmd_q;
  logic [ST_W-1:0]   xfer_state;
  logic              wr_ok, ctrl_we, en_we, sts_we, buf_we, cmd_we, rearm;
  logic              rx_load, seq_idle;
  logic [BYTE_W-1:0] rx_byte;
  eng_op_e           op_e;

  assign wr_ok   = reg_wr && seq_idle;
  assign ctrl_we = wr_ok && (reg_addr == AW'(RA_CTRL));
  assign en_we   = wr_ok && (reg_addr == AW'(RA_IEN));
  assign sts_we  = wr_ok && (reg_addr == AW'(RA_ISTS));
  assign buf_we  = wr_ok && (reg_addr == AW'(RA_BUF));
  assign cmd_we  = wr_ok && (reg_addr == AW'(RA_CMD)) && ctrl_q[0];
  assign rearm   = sts_we && reg_wdata[IB_RXDONE] && sts_q[IB_RXDONE];

  always_comb begin
    ctrl_d = ctrl_we ? (reg_wdata & CTRL_KEEP) : ctrl_q;
    buf_d  = buf_q;
    if (rx_load)     buf_d = {rx_byte, {BYTE_W{1'b0}}};
    else if (buf_we) buf_d = {{BYTE_W{1'b0}}, reg_wdata[BYTE_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ctrl_q <= '0;
      buf_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      buf_q  <= buf_d;
    end
  end

  i2cm_irq #(.INT_W(INT_W)) u_irq (
    .clk     (clk),
    .rst_n   (rst_ns),
    .en_we   (en_we),
    .sts_we  (sts_we),
    .wdata   (reg_wdata[INT_W-1:0]),
    .int_set (int_set),
    .en_q    (en_q),
    .sts_q   (sts_q),
    .irq     (irq)
  );

  i2cm_seq #(.INT_W(INT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_ns),
    .cmd_we       (cmd_we),
    .cmd_wdata    (reg_wdata[CMD_W-1:0]),
    .rearm        (rearm),
    .rx_blocked   (sts_q[IB_RXDONE]),
    .buf_lo       (buf_q[BYTE_W-1:0]),
    .eng_req      (eng_req),
    .eng_op       (op_e),
    .eng_addr     (eng_addr),
    .eng_rnw      (eng_rnw),
    .eng_wdata    (eng_wdata),
    .eng_nak_last (eng_nak_last),
    .eng_done     (eng_done),
    .eng_ack      (eng_ack),
    .eng_rdata    (eng_rdata),
    .eng_bus_busy (eng_bus_busy),
    .int_set      (int_set),
    .rx_load      (rx_load),
    .rx_byte      (rx_byte),
    .cmd_q        (cmd_q),
    .xfer_state   (xfer_state),
    .seq_idle     (seq_idle)
  );

  assign eng_op  = op_e;
  assign reg_rdy = seq_idle;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(RA_CTRL)) begin
      reg_rdata = ctrl_q;
    end else if (reg_addr == AW'(RA_IEN)) begin
      reg_rdata[INT_W-1:0] = en_q;
    end else if (reg_addr == AW'(RA_ISTS)) begin
      reg_rdata[INT_W-1:0] = sts_q;
    end else if (reg_addr == AW'(RA_BUF)) begin
      reg_rdata[BUF_W-1:0] = buf_q;
    end else if (reg_addr == AW'(RA_CMD)) begin
      reg_rdata[CMD_W-1:0]         = cmd_q;
      reg_rdata[BUSY_BIT]          = eng_bus_busy;
      reg_rdata[ST_LSB +: ST_W]    = xfer_state;
    end
  end
endmodule

// File: rtl/i2cm_front_chk.sv
`timescale 1ns/1ps
module i2cm_front_chk
  import i2cm_pkg::*;
#(
  parameter int AW    = 3,
  parameter int INT_W = 15
) (
  input logic              clk,
  input logic              rst_ns,
  input logic              reg_wr,
  input logic              reg_rdy,
  input logic [AW-1:0]     reg_addr,
  input logic              eng_req,
  input logic [1:0]        eng_op,
  input logic              eng_done,
  input logic [6:0]        eng_addr,
  input logic              eng_rnw,
  input logic [15:0]       buf_q,
  input logic [31:0]       ctrl_q,
  input logic [INT_W-1:0]  sts_q,
  input logic [3:0]        xfer_state
);
  // R12: request and opcode hold until completion
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_ns)
    eng_req && !eng_done |=> eng_req && $stable(eng_op));

  // R12: register port not ready while the engine is working
  p_rdy_low_r12: assert property (@(posedge clk) disable iff (!rst_ns)
    eng_req |-> !reg_rdy);

  // R2: command write without master enable starts nothing
  p_cmd_ignored_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    reg_wr && reg_rdy && (reg_addr == AW'(RA_CMD)) && !ctrl_q[0] |=> !eng_req);

  // R7: no receive request while receive-done is pending
  p_rx_blocked_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    eng_req && (eng_op == 2'(OP_RX)) |-> !sts_q[IB_RXDONE]);

  // R3: start carries the buffered address and direction
  p_start_addr_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    eng_req && (eng_op == 2'(OP_START)) |-> (eng_addr == buf_q[7:1]) && (eng_rnw == buf_q[0]));

  // R8: a completed stop returns the state to idle
  p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    eng_req && eng_done && (eng_op == 2'(OP_STOP)) && (xfer_state == XS_STOP) |=> xfer_state == XS_IDLE);
endmodule

bind i2cm_front i2cm_front_chk #(.AW(AW), .INT_W(INT_W)) u_chk (
  .clk        (clk),
  .rst_ns     (rst_ns),
  .reg_wr     (reg_wr),
  .reg_rdy    (reg_rdy),
  .reg_addr   (reg_addr),
  .eng_req    (eng_req),
  .eng_op     (eng_op),
  .eng_done   (eng_done),
  .eng_addr   (eng_addr),
  .eng_rnw    (eng_rnw),
  .buf_q      (buf_q),
  .ctrl_q     (ctrl_q),
  .sts_q      (sts_q),
  .xfer_state (xfer_state)
);

// File: tb/sim_i2cm_front.sv
`timescale 1ns/1ps
module sim_i2cm_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd4;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rdy, eng_req, eng_rnw, eng_nak_last, irq;
  logic [1:0]  eng_op;
  logic [6:0]  eng_addr;
  logic [7:0]  eng_wdata;
  logic        eng_done = 1'b0;
  logic        eng_ack = 1'b1;
  logic [7:0]  eng_rdata = '0;
  logic        eng_bus_busy = 1'b0;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;   // 50 MHz

  i2cm_front u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rdy(reg_rdy),
    .eng_req(eng_req), .eng_op(eng_op), .eng_addr(eng_addr), .eng_rnw(eng_rnw),
    .eng_wdata(eng_wdata), .eng_nak_last(eng_nak_last), .eng_done(eng_done),
    .eng_ack(eng_ack), .eng_rdata(eng_rdata), .eng_bus_busy(eng_bus_busy), .irq(irq)
  );

  // engine model: answers each request two cycles after it appears
  logic [1:0] dly = '0;
  logic [7:0] op_log = '0;
  int         nreq = 0;
  logic       log_clr = 1'b0;
  logic [3:0] last_st = '0;
  logic [3:0] start_st = '0;
  logic [6:0] addr_seen = '0;
  logic       rnw_seen = 1'b0;
  logic       nak_seen = 1'b0;
  logic [7:0] tx_seen = '0;

  always @(posedge clk) begin
    if (log_clr) begin
      op_log <= '0;
      nreq   <= 0;
    end
    if (eng_req && !eng_done) begin
      if (dly == 2'd2) begin
        eng_done <= 1'b1;
        dly      <= '0;
        op_log   <= {op_log[5:0], eng_op};
        nreq     <= nreq + 1;
        last_st  <= reg_rdata[22:19];
        if (eng_op == 2'd0) begin
          start_st  <= reg_rdata[22:19];
          addr_seen <= eng_addr;
          rnw_seen  <= eng_rnw;
        end
        if (eng_op == 2'd1) tx_seen <= eng_wdata;
        if (eng_op == 2'd2) nak_seen <= eng_nak_last;
      end else begin
        dly <= dly + 2'd1;
      end
    end else begin
      eng_done <= 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    while (!reg_rdy) @(negedge clk);
    reg_wr = 1'b1; reg_addr = a[2:0]; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 3'd4;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = a[2:0];
    #1 d = reg_rdata;
    reg_addr = 3'd4;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (!reg_rdy) @(negedge clk);
  endtask

  task automatic clear_log();
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
  endtask

  typedef struct packed {
    logic [7:0] bufv;
    logic [7:0] cmd;
    logic       ack;
    logic       busy;
    logic [7:0] rdata;
    logic [7:0] sts;
    logic [3:0] end_st;
    logic [7:0] log;
    logic [3:0] n;
    logic [3:0] last;
    logic [3:0] sst;     // state seen at start, 0 = no start
    logic       rx;
    logic       nak;
  } row_t;

  localparam int NROWS = 9;
  localparam row_t ROWS [NROWS] = '{
    '{8'hA0, 8'h23, 1'b1, 1'b1, 8'h00, 8'h11, 4'h0, 8'h03, 4'd2, 4'hB, 4'h9, 1'b0, 1'b0},
    '{8'h5A, 8'h02, 1'b1, 1'b1, 8'h00, 8'h01, 4'h8, 8'h01, 4'd1, 4'hC, 4'h0, 1'b0, 1'b0},
    '{8'h5A, 8'h20, 1'b1, 1'b1, 8'h00, 8'h10, 4'h0, 8'h03, 4'd1, 4'hB, 4'h0, 1'b0, 1'b0},
    '{8'h5A, 8'h20, 1'b1, 1'b1, 8'h00, 8'h20, 4'h0, 8'h00, 4'd0, 4'h0, 4'h0, 1'b0, 1'b0},
    '{8'hA1, 8'h29, 1'b1, 1'b1, 8'h3C, 8'h15, 4'h0, 8'h0B, 4'd3, 4'hB, 4'h9, 1'b1, 1'b0},
    '{8'hA0, 8'h21, 1'b0, 1'b0, 8'h00, 8'h02, 4'h9, 8'h00, 4'd1, 4'h9, 4'h9, 1'b0, 1'b0},
    '{8'hA0, 8'h20, 1'b1, 1'b1, 8'h00, 8'h10, 4'h0, 8'h03, 4'd1, 4'hB, 4'h0, 1'b0, 1'b0},
    '{8'h77, 8'h02, 1'b0, 1'b1, 8'h00, 8'h02, 4'h8, 8'h07, 4'd2, 4'h8, 4'h0, 1'b0, 1'b0},
    '{8'hA3, 8'h31, 1'b1, 1'b1, 8'hC5, 8'h15, 4'h0, 8'h0B, 4'd3, 4'hB, 4'hA, 1'b1, 1'b1}
  };

  initial begin
    #4_000_000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 enable", v, 0);
    rd(2, v); chk("R1 status", v, 0);
    rd(3, v); chk("R1 buffer", v, 0);
    rd(4, v); chk("R1 cmd/state", v, 0);
    chk("R1 rdy/req/irq", {29'd0, reg_rdy, eng_req, irq}, 32'h4);

    // R2 control mask and master-enable gate
    wr(0, 32'hFFFF_FFFF);
    rd(0, v); chk("R2 ctrl mask", v, 32'h0071_C3FF);
    wr(0, 32'h0);
    clear_log();
    wr(4, 32'h0000_0002);
    wait_idle();
    chk("R2 no request when disabled", nreq, 0);
    rd(4, v); chk("R2 cmd bits stay clear", v[5:0], 0);
    wr(0, 32'h1);

    // table: R3 R4 R5 R6 R8 R9
    for (int i = 0; i < NROWS; i++) begin
      wr(2, 32'h7FFF);
      clear_log();
      eng_ack = ROWS[i].ack; eng_bus_busy = ROWS[i].busy; eng_rdata = ROWS[i].rdata;
      wr(3, {24'd0, ROWS[i].bufv});
      wr(4, {24'd0, ROWS[i].cmd});
      wait_idle();
      rd(2, v); chk($sformatf("R4/R5/R8 row%0d status", i), v, {24'd0, ROWS[i].sts});
      rd(4, v); chk($sformatf("R8 row%0d end state", i), v[22:19], ROWS[i].end_st);
      chk($sformatf("R4 row%0d cmd cleared", i), v[5:0], 0);
      chk($sformatf("R9 row%0d op order", i), op_log, ROWS[i].log);
      chk($sformatf("R9 row%0d request count", i), nreq, ROWS[i].n);
      if (ROWS[i].n != 0)
        chk($sformatf("R5/R8 row%0d state during last op", i), last_st, ROWS[i].last);
      if (ROWS[i].sst != 0) begin
        chk($sformatf("R3 row%0d start state", i), start_st, ROWS[i].sst);
        chk($sformatf("R3 row%0d address", i), {24'd0, addr_seen, rnw_seen}, {24'd0, ROWS[i].bufv});
      end
      if (ROWS[i].rx) begin
        rd(3, v); chk($sformatf("R6 row%0d rx byte", i), v, {16'd0, ROWS[i].rdata, 8'd0});
        chk($sformatf("R6 row%0d nak-last", i), nak_seen, ROWS[i].nak);
      end
      if (ROWS[i].cmd == 8'h02)
        chk($sformatf("R5 row%0d tx byte", i), tx_seen, ROWS[i].bufv);
    end

    // R7 receive blocked, then re-armed by clearing receive-done
    wr(2, 32'h7FFF);
    eng_ack = 1'b1; eng_bus_busy = 1'b1;
    wr(3, 32'hA1);
    wr(4, 32'h01);
    wait_idle();
    eng_rdata = 8'h11;
    wr(4, 32'h08);
    wait_idle();
    rd(3, v); chk("R6 first rx byte", v, 32'h1100);
    clear_log();
    eng_rdata = 8'h22;
    wr(4, 32'h08);
    wait_idle();
    chk("R7 rx blocked no request", nreq, 0);
    rd(4, v); chk("R7 rx bit pending", v[3], 1);
    rd(3, v); chk("R7 buffer unchanged", v, 32'h1100);
    wr(2, 32'h4);
    wait_idle();
    chk("R7 rearm one request", nreq, 1);
    rd(3, v); chk("R7 rearm byte", v, 32'h2200);
    rd(4, v); chk("R7 rx bit cleared", v[3], 0);

    // R10 masking and partial W1C
    rd(2, v); chk("R10 status before clear", v, 32'h5);
    wr(1, 32'hFFFF_0004);
    rd(1, v); chk("R10 enable mask", v, 32'h4);
    chk("R10 irq on", irq, 1);
    wr(1, 32'h2);
    chk("R10 irq masked", irq, 0);
    wr(2, 32'hFFFF_0001);
    rd(2, v); chk("R10 partial clear", v, 32'h4);
    clear_log();
    wr(2, 32'h4);
    wait_idle();
    rd(2, v); chk("R10 cleared", v, 0);
    chk("R7 no rearm without pending rx", nreq, 0);

    // R11 busy and state fields
    eng_bus_busy = 1'b1;
    rd(4, v); chk("R11 busy bit", v[16], 1);
    chk("R11 state field", v[22:19], 4'h8);
    eng_bus_busy = 1'b0;
    rd(4, v); chk("R11 busy low", v[16], 0);

    // R12 not ready during a request, write ignored
    eng_bus_busy = 1'b1;
    wr(4, 32'h20);
    chk("R12 rdy low", reg_rdy, 0);
    reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h99;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 3'd4;
    wait_idle();
    rd(3, v); chk("R12 write while busy ignored", v, 32'h2200);
    rd(2, v); chk("R8 normal stop flag", v[4], 1);

    // R1 reset mid-run
    wr(3, 32'h55);
    wr(1, 32'h7FFF);
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(1, v); chk("R1 enable after reset", v, 0);
    rd(2, v); chk("R1 status after reset", v, 0);
    rd(3, v); chk("R1 buffer after reset", v, 0);
    rd(4, v); chk("R1 state after reset", v[22:0], 32'h0001_0000);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule